// File: doc/BRIEF.md
# Multi-Window Inbound Address Translator

This block sits between a PCIe-side bridge and a local AXI address space. It remaps 64-bit inbound memory request addresses through a bank of eight independently programmed windows. Each window holds a source base, a destination base, a size exponent and an enable. It also holds a security flag and a two-bit read/write attribute, and both are forwarded with every request that the window translates.

A request carries an address and a two-bit kind code. All windows compare the address in parallel. The lowest-numbered enabled window that matches supplies the new upper address bits, and the incoming address keeps its own offset bits. Interrupt messages and internal DMA requests bypass translation. A request that matches no window leaves with its address unchanged and the hit flag low.

The result is registered one cycle after acceptance, behind a valid/ready pair. Software programs the windows through a plain write/read register port.

Top module: `inbound_xlat`

## Requirements
- R1: Eight windows, indexed 0 to 7, each own a register set at byte offset `window*0x20`. Within a set, the control word sits at +0x00, the source base low/high at +0x04/+0x08, and the destination base low/high at +0x0C/+0x10. The control word layout is: bit 0 enable, bit 1 security, bits [3:2] attribute, bits [13:8] size exponent; all other bits read zero. Reads return the stored values combinationally.
- R2: A window hits only when it is enabled and the request address bits [63:12+size] equal its source base bits [63:12+size].
- R3: On a hit, the output address is destination base bits [63:12+size] joined with request address bits [11+size:0]. For example, source 0xFFA0_0000, destination 0x44A0_0000 and size 4 map 0xFFA0_1234 to 0x44A0_1234.
- R4: A window spans 2^(12+size) bytes, so the smallest window is 4 KB. Any size of 52 or more covers the whole 64-bit space and leaves the address unchanged on a hit.
- R5: A request of kind 1 (MSI), kind 2 (MSI-X) or kind 3 (internal DMA) never hits, and its address passes unchanged. Only kind 0, a memory request, is translated.
- R6: Bits [3:0] of the source base low word are stored as zero, whatever value is written.
- R7: On a hit, the security flag and attribute of the winning window appear on the response. On a miss, both are zero.
- R8: When several windows hit, the lowest-numbered one wins, and its index is reported.
- R9: On a miss, the hit flag is low, the reported index is 0 and the address is unchanged.
- R10: A request is accepted when `req_valid_i && req_ready_o`, and its result is valid on the next cycle. `req_ready_o` is high when no response is held or `rsp_ready_i` is high. A response that is held keeps its value until it is taken.
- R11: A register write applies to requests accepted on later clock edges. A request accepted on the same edge as the write still sees the old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 8 | Register byte address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data for reg_addr_i |
| req_valid_i | input | 1 | Request valid |
| req_ready_o | output | 1 | Request ready |
| req_addr_i | input | 64 | Request address |
| req_kind_i | input | 2 | 0 memory, 1 MSI, 2 MSI-X, 3 internal DMA |
| rsp_valid_o | output | 1 | Response valid |
| rsp_ready_i | input | 1 | Response ready |
| rsp_addr_o | output | 64 | Translated or passed-through address |
| rsp_hit_o | output | 1 | A window translated the request |
| rsp_win_o | output | 3 | Index of the winning window |
| rsp_secure_o | output | 1 | Security flag of the winning window |
| rsp_attr_o | output | 2 | Read/write attribute of the winning window |

## Verification
Each response field is due one clock edge after the edge that accepts the request. It then holds for as long as `rsp_ready_i` stays low. The bench model updates its expected response at each rising edge, from the inputs driven at the previous falling edge, and compares every output at the following falling edge. `req_ready_o` and the register read data are combinational. They are checked at the falling edge in the same cycle as their inputs.

// File: rtl/inbound_xlat_pkg.sv
package inbound_xlat_pkg;
  localparam int ADDR_W    = 64;
  localparam int SIZE_W    = 6;
  localparam int MIN_SHIFT = 12;
  localparam int FULL_SIZE = ADDR_W - MIN_SHIFT;

  typedef enum logic [1:0] {
    KIND_MEM  = 2'd0,
    KIND_MSI  = 2'd1,
    KIND_MSIX = 2'd2,
    KIND_DMA  = 2'd3
  } req_kind_e;

  typedef struct packed {
    logic              en;
    logic              sec;
    logic [1:0]        attr;
    logic [SIZE_W-1:0] size;
    logic [ADDR_W-1:0] src;
    logic [ADDR_W-1:0] dst;
  } win_cfg_t;

  // ones over the compared/replaced upper bits
  function automatic logic [ADDR_W-1:0] upper_mask(input logic [SIZE_W-1:0] sz);
    if (int'(sz) >= FULL_SIZE) return '0;
    return ~(({{(ADDR_W-1){1'b0}}, 1'b1} << (MIN_SHIFT + int'(sz))) - 1'b1);
  endfunction
endpackage

// File: rtl/xlat_regs.sv
module xlat_regs
  import inbound_xlat_pkg::*;
#(
  parameter int NUM_WIN = 8,
  localparam int WIN_AW = $clog2(NUM_WIN),
  localparam int REG_AW = WIN_AW + 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [REG_AW-1:0] addr_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  output win_cfg_t          cfg_o [NUM_WIN]
);
  localparam logic [2:0] OFF_CTRL   = 3'd0;
  localparam logic [2:0] OFF_SRC_LO = 3'd1;
  localparam logic [2:0] OFF_SRC_HI = 3'd2;
  localparam logic [2:0] OFF_DST_LO = 3'd3;
  localparam logic [2:0] OFF_DST_HI = 3'd4;

  logic [WIN_AW-1:0] win_sel;
  logic [2:0]        off;
  logic              win_ok;
  logic              unused_lsb;
  win_cfg_t          cfg_q [NUM_WIN];

  assign win_sel    = addr_i[REG_AW-1:5];
  assign off        = addr_i[4:2];
  assign win_ok     = int'(win_sel) < NUM_WIN;
  assign unused_lsb = ^addr_i[1:0];

  for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        cfg_q[w] <= '0;
      end else if (we_i && win_sel == WIN_AW'(w)) begin
        case (off)
          OFF_CTRL: begin
            cfg_q[w].en   <= wdata_i[0];
            cfg_q[w].sec  <= wdata_i[1];
            cfg_q[w].attr <= wdata_i[3:2];
            cfg_q[w].size <= wdata_i[8 +: SIZE_W];
          end
          OFF_SRC_LO: cfg_q[w].src[31:0]  <= {wdata_i[31:4], 4'h0};
          OFF_SRC_HI: cfg_q[w].src[63:32] <= wdata_i;
          OFF_DST_LO: cfg_q[w].dst[31:0]  <= wdata_i;
          OFF_DST_HI: cfg_q[w].dst[63:32] <= wdata_i;
          default: ;
        endcase
      end
    end

    p_ctrl_lands_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      we_i && win_sel == WIN_AW'(w) && off == OFF_CTRL
      |=> cfg_o[w].en == $past(wdata_i[0]) && cfg_o[w].size == $past(wdata_i[8 +: SIZE_W]));
    p_src_nibble_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      we_i && win_sel == WIN_AW'(w) && off == OFF_SRC_LO
      |=> cfg_o[w].src[3:0] == 4'h0 && cfg_o[w].src[31:4] == $past(wdata_i[31:4]));
  end

  assign cfg_o = cfg_q;

  always_comb begin
    rdata_o = '0;
    if (win_ok) begin
      case (off)
        OFF_CTRL:   rdata_o = {18'b0, cfg_q[win_sel].size, 4'b0, cfg_q[win_sel].attr,
                               cfg_q[win_sel].sec, cfg_q[win_sel].en};
        OFF_SRC_LO: rdata_o = cfg_q[win_sel].src[31:0];
        OFF_SRC_HI: rdata_o = cfg_q[win_sel].src[63:32];
        OFF_DST_LO: rdata_o = cfg_q[win_sel].dst[31:0];
        OFF_DST_HI: rdata_o = cfg_q[win_sel].dst[63:32];
        default:    rdata_o = '0;
      endcase
    end
  end
endmodule

// File: rtl/xlat_window_match.sv
module xlat_window_match
  import inbound_xlat_pkg::*;
(
  input  win_cfg_t          cfg_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              hit_o,
  output logic [ADDR_W-1:0] xaddr_o
);
  logic [ADDR_W-1:0] mask;

  assign mask    = upper_mask(cfg_i.size);
  assign hit_o   = cfg_i.en && (((addr_i ^ cfg_i.src) & mask) == '0);
  assign xaddr_o = (cfg_i.dst & mask) | (addr_i & ~mask);
endmodule

// File: rtl/xlat_select.sv
module xlat_select
  import inbound_xlat_pkg::*;
#(
  parameter int NUM_WIN = 8,
  localparam int WIN_AW = $clog2(NUM_WIN)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              acc_i,
  input  logic [1:0]        kind_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [NUM_WIN-1:0] hit_vec_i,
  input  logic [ADDR_W-1:0] xaddr_i [NUM_WIN],
  input  win_cfg_t          cfg_i [NUM_WIN],
  input  logic              rsp_ready_i,
  output logic              rsp_valid_o,
  output logic [ADDR_W-1:0] rsp_addr_o,
  output logic              rsp_hit_o,
  output logic [WIN_AW-1:0] rsp_win_o,
  output logic              rsp_secure_o,
  output logic [1:0]        rsp_attr_o
);
  logic              g_hit;
  logic [WIN_AW-1:0] g_idx;
  logic [ADDR_W-1:0] g_addr;
  logic              g_sec;
  logic [1:0]        g_attr;

  always_comb begin
    g_hit  = 1'b0;
    g_idx  = '0;
    g_addr = addr_i;
    g_sec  = 1'b0;
    g_attr = 2'b0;
    // descending scan: the lowest index is written last and wins
    for (int w = NUM_WIN - 1; w >= 0; w--) begin
      if (hit_vec_i[w]) begin
        g_hit  = 1'b1;
        g_idx  = WIN_AW'(w);
        g_addr = xaddr_i[w];
        g_sec  = cfg_i[w].sec;
        g_attr = cfg_i[w].attr;
      end
    end
    if (kind_i != KIND_MEM) begin
      g_hit  = 1'b0;
      g_idx  = '0;
      g_addr = addr_i;
      g_sec  = 1'b0;
      g_attr = 2'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o  <= 1'b0;
      rsp_addr_o   <= '0;
      rsp_hit_o    <= 1'b0;
      rsp_win_o    <= '0;
      rsp_secure_o <= 1'b0;
      rsp_attr_o   <= 2'b0;
    end else begin
      if (acc_i) begin
        rsp_valid_o  <= 1'b1;
        rsp_addr_o   <= g_addr;
        rsp_hit_o    <= g_hit;
        rsp_win_o    <= g_idx;
        rsp_secure_o <= g_sec;
        rsp_attr_o   <= g_attr;
      end else if (rsp_ready_i) begin
        rsp_valid_o  <= 1'b0;
      end
    end
  end

  p_accept_valid_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_i |=> rsp_valid_o);
  p_stall_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o && !rsp_ready_i |=> rsp_valid_o && $stable(rsp_addr_o) && $stable(rsp_win_o)
      && $stable(rsp_hit_o));
  p_bypass_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_i && kind_i != KIND_MEM |=> !rsp_hit_o && rsp_addr_o == $past(addr_i));
  p_lowest_wins_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_i && kind_i == KIND_MEM && hit_vec_i[0] |=> rsp_hit_o && rsp_win_o == '0);
  p_miss_clean_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o && !rsp_hit_o |-> rsp_win_o == '0 && !rsp_secure_o && rsp_attr_o == 2'b0);
endmodule

// File: rtl/inbound_xlat.sv
module inbound_xlat
  import inbound_xlat_pkg::*;
#(
  parameter int NUM_WIN = 8,
  localparam int WIN_AW = $clog2(NUM_WIN),
  localparam int REG_AW = WIN_AW + 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [REG_AW-1:0] reg_addr_i,
  input  logic [31:0]       reg_wdata_i,
  output logic [31:0]       reg_rdata_o,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [63:0]       req_addr_i,
  input  logic [1:0]        req_kind_i,
  output logic              rsp_valid_o,
  input  logic              rsp_ready_i,
  output logic [63:0]       rsp_addr_o,
  output logic              rsp_hit_o,
  output logic [WIN_AW-1:0] rsp_win_o,
  output logic              rsp_secure_o,
  output logic [1:0]        rsp_attr_o
);
  win_cfg_t          cfg [NUM_WIN];
  logic [NUM_WIN-1:0] hit_vec;
  logic [ADDR_W-1:0] xaddr [NUM_WIN];
  logic              acc;

  assign req_ready_o = !rsp_valid_o || rsp_ready_i;
  assign acc         = req_valid_i && req_ready_o;

  xlat_regs #(.NUM_WIN(NUM_WIN)) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (reg_we_i),
    .addr_i  (reg_addr_i),
    .wdata_i (reg_wdata_i),
    .rdata_o (reg_rdata_o),
    .cfg_o   (cfg)
  );

  for (genvar w = 0; w < NUM_WIN; w++) begin : g_match
    xlat_window_match u_match (
      .cfg_i   (cfg[w]),
      .addr_i  (req_addr_i),
      .hit_o   (hit_vec[w]),
      .xaddr_o (xaddr[w])
    );
  end

  xlat_select #(.NUM_WIN(NUM_WIN)) u_select (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .acc_i        (acc),
    .kind_i       (req_kind_i),
    .addr_i       (req_addr_i),
    .hit_vec_i    (hit_vec),
    .xaddr_i      (xaddr),
    .cfg_i        (cfg),
    .rsp_ready_i  (rsp_ready_i),
    .rsp_valid_o  (rsp_valid_o),
    .rsp_addr_o   (rsp_addr_o),
    .rsp_hit_o    (rsp_hit_o),
    .rsp_win_o    (rsp_win_o),
    .rsp_secure_o (rsp_secure_o),
    .rsp_attr_o   (rsp_attr_o)
  );

  p_backpressure_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o && !rsp_ready_i |-> !req_ready_o);
endmodule

// File: tb/inbound_xlat_tb_top.sv
module inbound_xlat_tb_top;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        reg_we = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [63:0] req_addr = '0;
  logic [1:0]  req_kind = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b1;
  logic [63:0] rsp_addr;
  logic        rsp_hit;
  logic [2:0]  rsp_win;
  logic        rsp_sec;
  logic [1:0]  rsp_attr;

  int n_chk = 0;
  int n_fail = 0;

  logic [63:0] m_src [8];
  logic [63:0] m_dst [8];
  int          m_size [8];
  bit          m_en [8];
  bit          m_sec [8];
  bit [1:0]    m_attr [8];

  bit          e_valid = 0;
  logic [63:0] e_addr = '0;
  bit          e_hit = 0;
  int          e_win = 0;
  bit          e_sec = 0;
  bit [1:0]    e_attr = 0;

  always #5 clk = ~clk;

  inbound_xlat dut_i (
    .clk_i(clk), .rst_ni(rst_ni),
    .reg_we_i(reg_we), .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_addr_i(req_addr), .req_kind_i(req_kind),
    .rsp_valid_o(rsp_valid), .rsp_ready_i(rsp_ready), .rsp_addr_o(rsp_addr), .rsp_hit_o(rsp_hit),
    .rsp_win_o(rsp_win), .rsp_secure_o(rsp_sec), .rsp_attr_o(rsp_attr)
  );

  task automatic report();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  task automatic chk(string tag, logic [63:0] got, logic [63:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h at %0t", tag, got, exp, $time);
    end
  endtask

  // behavioural reference: shift-and-compare per window, first enabled match in index order
  task automatic model_xlat(logic [63:0] a, logic [1:0] k);
    e_addr = a; e_hit = 0; e_win = 0; e_sec = 0; e_attr = 0;
    if (k != 2'd0) return;
    for (int w = 0; w < 8; w++) begin
      int sh;
      if (!m_en[w]) continue;
      sh = 12 + m_size[w];
      if (sh >= 64 || (a >> sh) == (m_src[w] >> sh)) begin
        e_hit = 1; e_win = w; e_sec = m_sec[w]; e_attr = m_attr[w];
        if (sh < 64) e_addr = ((m_dst[w] >> sh) << sh) + (a - ((a >> sh) << sh));
        return;
      end
    end
  endtask

  task automatic model_write(logic [7:0] a, logic [31:0] d);
    int w = int'(a) / 32;
    int o = (int'(a) / 4) % 8;
    case (o)
      0: begin m_en[w] = d[0]; m_sec[w] = d[1]; m_attr[w] = d[3:2]; m_size[w] = int'(d[13:8]); end
      1: m_src[w][31:0] = {d[31:4], 4'h0};
      2: m_src[w][63:32] = d;
      3: m_dst[w][31:0] = d;
      4: m_dst[w][63:32] = d;
      default: ;
    endcase
  endtask

  task automatic tick();
    @(posedge clk);
    if (rst_ni) begin
      if (req_valid && (!e_valid || rsp_ready)) begin
        model_xlat(req_addr, req_kind);
        e_valid = 1;
      end else if (rsp_ready) begin
        e_valid = 0;
      end
      if (reg_we) model_write(reg_addr, reg_wdata);
    end
    @(negedge clk);
    chk("R10 valid", {63'b0, rsp_valid}, {63'b0, e_valid});
    chk("R10 ready", {63'b0, req_ready}, {63'b0, (!e_valid || rsp_ready)});
    if (e_valid) begin
      chk("R3 addr", rsp_addr, e_addr);
      chk("R2 hit", {63'b0, rsp_hit}, {63'b0, e_hit});
      chk("R8 win", {61'b0, rsp_win}, 64'(e_win));
      chk("R7 sec", {63'b0, rsp_sec}, {63'b0, e_sec});
      chk("R7 attr", {62'b0, rsp_attr}, {62'b0, e_attr});
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    reg_we = 1; reg_addr = a; reg_wdata = d;
    tick();
    reg_we = 0;
  endtask

  task automatic rdchk(string tag, logic [7:0] a, logic [31:0] exp);
    reg_addr = a;
    #1;
    chk(tag, {32'b0, reg_rdata}, {32'b0, exp});
  endtask

  task automatic prog(int w, logic [63:0] s, logic [63:0] d, int sz, bit en, bit sec, bit [1:0] at);
    logic [7:0] b = 8'(w * 32);
    wr(b + 8'h04, s[31:0]);
    wr(b + 8'h08, s[63:32]);
    wr(b + 8'h0C, d[31:0]);
    wr(b + 8'h10, d[63:32]);
    wr(b, {18'b0, 6'(sz), 4'b0, at, sec, en});
  endtask

  task automatic req(logic [63:0] a, logic [1:0] k);
    req_valid = 1; req_addr = a; req_kind = k;
    tick();
    req_valid = 0;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_fail++; n_chk++;
    $display("FAIL watchdog: got timeout expected completion");
    report();
    $finish;
  end

  initial begin
    for (int w = 0; w < 8; w++) begin
      m_src[w] = '0; m_dst[w] = '0; m_size[w] = 0; m_en[w] = 0; m_sec[w] = 0; m_attr[w] = 0;
    end
    repeat (3) @(negedge clk);
    rst_ni = 1;
    // reset state
    chk("R10 reset valid", {63'b0, rsp_valid}, 64'd0);
    chk("R10 reset ready", {63'b0, req_ready}, 64'd1);
    rdchk("R1 reset ctrl", 8'h00, 32'h0);
    // miss with nothing enabled
    req(64'h0000_1234_5678_9ABC, 2'd0);
    chk("R9 passthrough", rsp_addr, 64'h0000_1234_5678_9ABC);
    // window 0: 64 KB, low nibble of source written nonzero
    prog(0, 64'h0000_0000_FFA0_000F, 64'h0000_0000_44A0_0000, 4, 1, 1, 2'd2);
    rdchk("R6 src nibble", 8'h04, 32'hFFA0_0000);
    rdchk("R1 ctrl readback", 8'h00, 32'h0000_040B);
    rdchk("R1 dst readback", 8'h0C, 32'h44A0_0000);
    req(64'h0000_0000_FFA0_1234, 2'd0);
    chk("R3 example", rsp_addr, 64'h0000_0000_44A0_1234);
    chk("R7 sec on hit", {63'b0, rsp_sec}, 64'd1);
    req(64'h0000_0000_FFA0_FFFF, 2'd0);
    chk("R4 last byte in window", {63'b0, rsp_hit}, 64'd1);
    req(64'h0000_0000_FFA1_0000, 2'd0);
    chk("R4 first byte past window", {63'b0, rsp_hit}, 64'd0);
    // excluded kinds
    for (int k = 1; k < 4; k++) begin
      req(64'h0000_0000_FFA0_1234, 2'(k));
      chk("R5 no translate", rsp_addr, 64'h0000_0000_FFA0_1234);
    end
    // overlapping windows 3 and 5
    prog(3, 64'h0000_0001_0000_0000, 64'h0000_0000_8000_0000, 20, 1, 0, 2'd1);
    prog(5, 64'h0000_0001_0000_0000, 64'h0000_0000_9000_0000, 8, 1, 1, 2'd3);
    req(64'h0000_0001_0000_0ABC, 2'd0);
    chk("R8 lowest wins", {61'b0, rsp_win}, 64'd3);
    wr(8'h60, 32'h0);
    req(64'h0000_0001_0000_0ABC, 2'd0);
    chk("R11 after disable", {61'b0, rsp_win}, 64'd5);
    chk("R3 window 5 splice", rsp_addr, 64'h0000_0000_9000_0ABC);
    // write and accept on the same edge
    reg_we = 1; reg_addr = 8'h00; reg_wdata = 32'h0;
    req_valid = 1; req_addr = 64'h0000_0000_FFA0_0040; req_kind = 0;
    tick();
    reg_we = 0; req_valid = 0;
    chk("R11 same edge old value", {63'b0, rsp_hit}, 64'd1);
    req(64'h0000_0000_FFA0_0040, 2'd0);
    chk("R11 next request new value", {63'b0, rsp_hit}, 64'd0);
    chk("R9 miss index", {61'b0, rsp_win}, 64'd0);
    wr(8'h00, 32'h0000_040B);
    // backpressure
    rsp_ready = 0;
    req_valid = 1; req_addr = 64'h0000_0000_FFA0_0100; req_kind = 0;
    tick();
    req_addr = 64'h0000_0000_FFA0_0200;
    repeat (3) tick();
    chk("R10 held", rsp_addr, 64'h0000_0000_44A0_0100);
    rsp_ready = 1;
    tick();
    req_valid = 0;
    tick();
    // mixed stream
    for (int i = 0; i < 400; i++) begin
      int sel = int'($urandom_range(0, 3));
      logic [63:0] base = (sel == 0) ? 64'h0000_0000_FFA0_0000 :
                          (sel == 1) ? 64'h0000_0001_0000_0000 :
                          (sel == 2) ? 64'h0000_0001_0010_0000 : {$urandom, $urandom};
      req_valid = ($urandom_range(0, 3) != 0);
      req_addr  = base + 64'($urandom_range(0, 32'h1_FFFF));
      req_kind  = ($urandom_range(0, 5) == 0) ? 2'($urandom_range(1, 3)) : 2'd0;
      rsp_ready = ($urandom_range(0, 3) != 0);
      tick();
    end
    req_valid = 0; rsp_ready = 1;
    tick();
    // whole-space window
    prog(7, 64'h0, 64'hDEAD_0000_0000_0000, 52, 1, 0, 2'd1);
    req(64'h7777_0000_1234_0000, 2'd0);
    chk("R4 full span hit", {63'b0, rsp_hit}, 64'd1);
    chk("R4 full span addr", rsp_addr, 64'h7777_0000_1234_0000);
    chk("R8 full span index", {61'b0, rsp_win}, 64'd7);
    tick();
    report();
    $finish;
  end
endmodule